// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt requests from eight peripheral lines and presents them to a processor on a single interrupt output. A request is captured on the rising edge of its line and held pending until the processor services it. When the processor pulses its acknowledge input, the controller drives an 8-bit vector onto the data bus in that same cycle. The vector is made of a software-loaded 5-bit base and the 3-bit index of the winning line. At the same clock edge the controller moves the winner from the pending set into the in-service set.

Line 0 has the highest priority and line 7 the lowest. The in-service set records which handlers are running. A pending line raises the interrupt output only if its priority is strictly higher than every handler in progress, so handlers can nest but never pre-empt themselves or a more urgent handler. An end-of-service pulse retires the most urgent running handler. Pending lines that were held back may then be presented.

Top module: `vpic_ctrl`

## Requirements
- R1: After reset the pending set, the in-service set and the vector base are all zero, `int_out` is low and `vec_valid` is low.
- R2: A low-to-high transition on `irq_in[i]` marks line i pending from the next clock edge. A line that stays high does not request again once its request has been taken.
- R3: `int_out` is high exactly when some line is pending whose index is lower than the lowest in-service index, or when any line is pending and nothing is in service.
- R4: When several eligible lines are pending, the acknowledge selects the lowest index.
- R5: While `ack` is high and `int_out` is high, `vec_valid` is high and `vec_out[7:3]` equals the base and `vec_out[2:0]` equals the selected index. `base_we` loads `base_in` into the base at the clock edge.
- R6: A valid acknowledge clears the selected pending bit and sets its in-service bit at the same clock edge.
- R7: A pending line at equal or lower priority than the most urgent in-service line keeps `int_out` low. A strictly higher line raises it, so handlers nest.
- R8: An `eos` pulse clears the lowest-indexed set in-service bit. Lines it was holding back then become eligible.
- R9: An `ack` while `int_out` is low leaves `vec_valid` low and changes neither the pending set nor the in-service set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Peripheral request lines, index 0 most urgent |
| base_we | input | 1 | Load strobe for the vector base |
| base_in | input | 5 | New vector base |
| ack | input | 1 | One-cycle acknowledge pulse from the processor |
| eos | input | 1 | One-cycle end-of-service pulse |
| int_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector on `vec_out` is valid this cycle |
| vec_out | output | 8 | Vector: base in the upper five bits, line index in the lower three |

## Verification
The assertions assume that `ack` and `eos` are single-cycle pulses and that they do not arrive in the same cycle. The in-service count check is only meaningful when a retirement does not coincide with a new entry. The bench drives every control input as an isolated one-cycle pulse, with idle cycles in between. It changes request lines only between acknowledges, so each acknowledge sees a settled pending set.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
    parameter int unsigned NUM_SRC = 8;
    parameter int unsigned BASE_W  = 5;
    localparam int unsigned IDX_W  = $clog2(NUM_SRC);
    localparam int unsigned VEC_W  = BASE_W + IDX_W;

    typedef logic [NUM_SRC-1:0] src_mask_t;
    typedef logic [IDX_W-1:0]   src_idx_t;
    typedef logic [BASE_W-1:0]  base_t;

    typedef struct packed {
        logic     hit;
        src_idx_t idx;
    } pick_t;

    typedef struct packed {
        base_t    base;
        src_idx_t idx;
    } vector_t;

    // lowest set index wins
    function automatic pick_t pick_first(input src_mask_t m);
        pick_t r;
        r = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (m[i]) begin
                r.hit = 1'b1;
                r.idx = src_idx_t'(i);
            end
        end
        return r;
    endfunction

    // lines strictly more urgent than the given level (all lines if none)
    function automatic src_mask_t above_mask(input pick_t lvl);
        src_mask_t r;
        for (int i = 0; i < NUM_SRC; i++)
            r[i] = !lvl.hit || (src_idx_t'(i) < lvl.idx);
        return r;
    endfunction

    // lines at or more urgent than the given index
    function automatic src_mask_t at_or_above(input src_idx_t idx);
        src_mask_t r;
        for (int i = 0; i < NUM_SRC; i++)
            r[i] = (src_idx_t'(i) <= idx);
        return r;
    endfunction

    function automatic src_mask_t onehot(input pick_t p);
        src_mask_t r;
        r = '0;
        if (p.hit)
            r[p.idx] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/vpic_req_latch.sv
module vpic_req_latch
    import vpic_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  src_mask_t irq_in,
    input  src_mask_t clr_mask,
    output src_mask_t pend
);
    src_mask_t irq_q;
    src_mask_t rise;

    assign rise = irq_in & ~irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= '0;
            pend  <= '0;
        end else begin
            irq_q <= irq_in;
            pend  <= (pend & ~clr_mask) | rise;
        end
    end

    // R6
    pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (|(clr_mask & ~rise)) |=> ((pend & $past(clr_mask & ~rise)) == '0));

    // R2
    pend_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (|rise) |=> ((pend & $past(rise)) == $past(rise)));
endmodule

// File: rtl/vpic_resolver.sv
module vpic_resolver
    import vpic_pkg::*;
(
    input  src_mask_t pend,
    input  src_mask_t isr,
    output pick_t     grant
);
    pick_t     top_isr;
    src_mask_t eligible;

    always_comb begin
        top_isr  = pick_first(isr);
        eligible = pend & above_mask(top_isr);
        grant    = pick_first(eligible);
    end
endmodule

// File: rtl/vpic_inservice.sv
module vpic_inservice
    import vpic_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  src_mask_t set_mask,
    input  logic      eos,
    output src_mask_t isr
);
    src_mask_t clr_mask;

    always_comb begin
        clr_mask = eos ? onehot(pick_first(isr)) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            isr <= '0;
        else
            isr <= (isr & ~clr_mask) | set_mask;
    end

    // R6
    set_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(set_mask));

    // R8
    eos_retire_chk: assert property (@(posedge clk) disable iff (rst)
        (eos && set_mask == '0 && isr != '0)
        |=> ($countones(isr) == $countones($past(isr)) - 1));
endmodule

// File: rtl/vpic_ctrl.sv
module vpic_ctrl
    import vpic_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC-1:0]   irq_in,
    input  logic                 base_we,
    input  logic [BASE_W-1:0]    base_in,
    input  logic                 ack,
    input  logic                 eos,
    output logic                 int_out,
    output logic                 vec_valid,
    output logic [VEC_W-1:0]     vec_out
);
    src_mask_t pend;
    src_mask_t isr;
    src_mask_t take_mask;
    pick_t     grant;
    base_t     base_q;
    vector_t   vec;

    vpic_req_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .irq_in   (irq_in),
        .clr_mask (take_mask),
        .pend     (pend)
    );

    vpic_resolver u_res (
        .pend  (pend),
        .isr   (isr),
        .grant (grant)
    );

    vpic_inservice u_isr (
        .clk      (clk),
        .rst      (rst),
        .set_mask (take_mask),
        .eos      (eos),
        .isr      (isr)
    );

    always_ff @(posedge clk) begin
        if (rst)
            base_q <= '0;
        else if (base_we)
            base_q <= base_in;
    end

    always_comb begin
        int_out   = grant.hit;
        vec_valid = ack && grant.hit;
        take_mask = vec_valid ? onehot(grant) : '0;
        vec.base  = base_q;
        vec.idx   = grant.idx;
        vec_out   = vec_valid ? vec : '0;
    end

    // R3
    int_has_pend_chk: assert property (@(posedge clk) disable iff (rst)
        int_out |-> (pend != '0));

    // R5
    vec_src_pend_chk: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> pend[vec_out[IDX_W-1:0]]);

    // R7
    nest_only_higher_chk: assert property (@(posedge clk) disable iff (rst)
        int_out |-> ((isr & at_or_above(grant.idx)) == '0));

    // R9
    spurious_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !int_out && !eos) |=> ($stable(isr)));
endmodule

// File: tb/tb_vpic_ctrl.sv
module tb_vpic_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_in = '0;
    logic       base_we = 1'b0;
    logic [4:0] base_in = '0;
    logic       ack = 1'b0;
    logic       eos = 1'b0;
    logic       int_out;
    logic       vec_valid;
    logic [7:0] vec_out;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    bit done = 0;

    always #10 clk = ~clk;

    vpic_ctrl dut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .base_we(base_we),
        .base_in(base_in), .ack(ack), .eos(eos), .int_out(int_out),
        .vec_valid(vec_valid), .vec_out(vec_out)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // monitor: pops expected vectors as the design produces them (R4, R5)
    always @(negedge clk) begin
        if (!rst && vec_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R9 unexpected vector actual=%h expected=none", vec_out);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (vec_out !== e) begin
                    errors++;
                    $display("FAIL R5 vector actual=%h expected=%h", vec_out, e);
                end
            end
        end
    end

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #2;
    endtask

    task automatic chk(string req, logic act, logic exp);
        @(negedge clk);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
        cyc(1);
    endtask

    task automatic chk_int(string req, logic exp);
        @(negedge clk);
        checks++;
        if (int_out !== exp) begin
            errors++;
            $display("FAIL %s int_out actual=%b expected=%b", req, int_out, exp);
        end
        cyc(1);
    endtask

    // driver: acknowledge and push the expected vector
    task automatic do_ack(logic [7:0] e);
        exp_q.push_back(e);
        ack = 1'b1;
        cyc(1);
        ack = 1'b0;
        cyc(1);
    endtask

    task automatic do_eos();
        eos = 1'b1;
        cyc(1);
        eos = 1'b0;
        cyc(1);
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        // R1 reset state
        @(negedge clk);
        checks++;
        if (int_out !== 1'b0 || vec_valid !== 1'b0 || vec_out !== 8'h00) begin
            errors++;
            $display("FAIL R1 actual=%b%b%h expected=000", int_out, vec_valid, vec_out);
        end
        cyc(1);

        // R5 base load
        base_in = 5'h12; base_we = 1'b1; cyc(1); base_we = 1'b0; cyc(1);

        // R2, R3: two lines rise together
        irq_in[3] = 1'b1; irq_in[5] = 1'b1; cyc(2);
        chk_int("R3 pending raises", 1'b1);
        do_ack(8'h93);                         // R4 line 3 beats 5
        chk_int("R7 lower than in-service", 1'b0);
        irq_in[6] = 1'b1; cyc(2);
        chk_int("R7 line6 held back", 1'b0);
        irq_in[3] = 1'b0; irq_in[3] = 1'b1;    // no edge seen: stays high
        irq_in[1] = 1'b1; cyc(2);
        chk_int("R7 nesting higher line", 1'b1);
        do_ack(8'h91);                         // R6
        chk_int("R6 line1 taken", 1'b0);
        do_eos();                              // R8 retires line 1
        chk_int("R8 line3 still in service", 1'b0);
        do_eos();                              // R8 retires line 3
        chk_int("R8 held lines released", 1'b1);
        do_ack(8'h95);                         // R4 line 5 beats 6
        do_eos();
        do_ack(8'h96);
        do_eos();
        chk_int("R2 held lines do not re-request", 1'b0);

        // R9 spurious acknowledge
        ack = 1'b1;
        chk("R9 vec_valid low on spurious ack", vec_valid, 1'b0);
        ack = 1'b0; cyc(1);
        irq_in = '0; cyc(2);
        irq_in[7] = 1'b1; cyc(2);
        chk_int("R9 in-service unchanged after spurious ack", 1'b1);
        irq_in[0] = 1'b1; cyc(2);
        do_ack(8'h90);                         // R4 line 0
        chk_int("R7 line7 behind line0", 1'b0);
        do_eos();
        chk_int("R8 line7 eligible again", 1'b1);
        base_in = 5'h1F; base_we = 1'b1; cyc(1); base_we = 1'b0; cyc(1);
        do_ack(8'hFF);                         // R5 new base
        do_eos();
        chk_int("R2 idle after all serviced", 1'b0);
        irq_in[7] = 1'b0; cyc(1); irq_in[7] = 1'b1; cyc(2);
        chk_int("R2 new edge requests again", 1'b1);
        do_ack(8'hFF);
        do_eos();

        cyc(2);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R5 missing vectors actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end
endmodule